// File: doc/BRIEF.md
# Iterative AND-Rotate-XOR Feistel Cipher Core (64-bit block, 128-bit key)

This block encrypts or decrypts a single 64-bit block under a 128-bit key. The cipher is a two-word Feistel network with 32-bit words, iterated for 44 rounds. Its only nonlinear step is a bitwise AND of two rotated copies of the left word. Round keys are not supplied from outside. The core expands them on the fly from the four key words, one key per clock. Each key mixes in one bit of a fixed 62-entry constant sequence, and that sequence repeats.

A caller pulses `start_i` with the block, the key and the mode bit, and then waits for the one-cycle `done_o` pulse. Encryption and decryption share one round datapath. For decryption, the core swaps the input words, runs the key expansion forward to the last round key, and then supplies the keys in reverse order. It does this either by running the key recurrence backward or by reading a stored key file, as a parameter selects. At the end it swaps the output words. While `busy_o` is high, a new request is ignored.

Top module: `simon_core`

## Requirements
- R1: One round maps the word pair (x, y) to (y ^ f(x) ^ k, x). Here f(x) = (rotl(x,1) & rotl(x,8)) ^ rotl(x,2) and k is that round's key. An encryption applies 44 such rounds with round keys k0..k43. No key is added before the first round or after the last.
- R2: The round keys k0..k3 are the key words. Each later key is k(i+4) = k(i) ^ t ^ rotr(t,1) ^ 0xFFFFFFFC ^ z(i), where t = rotr(k(i+3),3) ^ k(i+1). The constant bit z(i) is character (i mod 62), counted from the left, of the string 11011011101011000110010111100000010010001010011100110100001111.
- R3: Encrypting block 0x656b696c20646e75 under key 0x1b1a1918131211100b0a090803020100 gives 0x44c8fc20b9dfa07a.
- R4: Field placement is as follows. Word x is `block_i[63:32]`, and word y is `block_i[31:0]`. Key word k(j) is `key_i[32*j+31:32*j]`. The result on `block_o` uses the same x and y positions.
- R5: An encryption request is accepted on a rising edge where `start_i` is 1 and `busy_o` is 0. For that request, `done_o` is first high after the 44th rising edge that follows the accepting edge. `busy_o` is high from the accepting edge until that 44th edge.
- R6: When `decrypt_i` is 1 at acceptance, the core returns the plaintext whose encryption under the same key is the input block. `done_o` then follows the 87th rising edge after acceptance: 43 key-expansion cycles plus 44 rounds.
- R7: A start pulse while `busy_o` is high is ignored. The running operation finishes at its original time with its original result, whatever block, key or mode comes with the ignored pulse.
- R8: `done_o` stays high for exactly one cycle, and `busy_o` is low whenever `done_o` is high. After completion, `block_o` holds the result until the next accepted request.
- R9: After reset, `busy_o`, `done_o` and `block_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request pulse, honoured only when idle |
| decrypt_i | input | 1 | 1 selects decryption, 0 encryption; sampled with the request |
| block_i | input | 64 | Input block, x in upper half, y in lower half |
| key_i | input | 128 | Key, word j in bits 32*j+31..32*j |
| busy_o | output | 1 | High while an operation is running |
| done_o | output | 1 | One-cycle completion pulse |
| block_o | output | 64 | Result block, held after completion |

## Verification
Every round key feeds every later round. A single wrong key word, a wrong constant bit, or a wrong step direction in the schedule therefore corrupts the whole 64-bit result. That corruption is visible at `block_o` in the `done_o` cycle of the same request. A mode latched wrongly shows up in the same cycle, either as swapped halves or as a failed round trip. An off-by-one in the round or preparation counter shows up as `done_o` arriving one cycle early or late, or as a wrong result. A request that is wrongly accepted during a busy period shows up as a shifted completion or a changed result for the operation already in flight.

// File: rtl/simon_pkg.sv
package simon_pkg;

   // control sequencing of one request
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_PREP = 2'd1,
      ST_RUN  = 2'd2
   } core_state_e;

   // source of reversed round keys during decryption
   typedef enum int {
      REVKEY_RECOMPUTE = 0,
      REVKEY_STORED    = 1
   } revkey_mode_e;

endpackage

// File: rtl/simon_round.sv
module simon_round #(
   parameter int WORD  = 32,
   parameter int ROT_A = 1,
   parameter int ROT_B = 8,
   parameter int ROT_C = 2
) (
   input  logic [WORD-1:0] x_i,
   input  logic [WORD-1:0] y_i,
   input  logic [WORD-1:0] rk_i,
   output logic [WORD-1:0] x_o,
   output logic [WORD-1:0] y_o
);

   generate
      if (ROT_A >= WORD || ROT_B >= WORD || ROT_C >= WORD) begin : g_bad_rot
         $error("simon_round: rotation amount must be below WORD");
      end
   endgenerate

   logic [WORD-1:0] mix;

   // bit b of rotl(x,s) is bit (b - s) mod WORD of x
   genvar b;
   generate
      for (b = 0; b < WORD; b++) begin : g_bit
         localparam int IA = (b + WORD - ROT_A) % WORD;
         localparam int IB = (b + WORD - ROT_B) % WORD;
         localparam int IC = (b + WORD - ROT_C) % WORD;
         assign mix[b] = (x_i[IA] & x_i[IB]) ^ x_i[IC];
      end
   endgenerate

   assign x_o = y_i ^ mix ^ rk_i;
   assign y_o = x_i;

endmodule

// File: rtl/simon_keysched.sv
module simon_keysched #(
   parameter int                WORD    = 32,
   parameter int                ROUNDS  = 44,
   parameter int                ZLEN    = 62,
   parameter logic [ZLEN-1:0]   ZSEQ    = 62'b11011011101011000110010111100000010010001010011100110100001111,
   parameter int                REVKEY  = 0,
   localparam int               CNT_W   = $clog2(ROUNDS)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load_i,
   input  logic [4*WORD-1:0]  key_i,
   input  logic               fwd_i,
   input  logic               bwd_i,
   input  logic               prep_i,
   input  logic               rev_i,
   input  logic [CNT_W-1:0]   idx_i,
   output logic [WORD-1:0]    rk_o
);

   localparam logic [WORD-1:0] KCONST = {{(WORD-2){1'b1}}, 2'b00};

   generate
      if (WORD < 4) begin : g_bad_word
         $error("simon_keysched: WORD too small");
      end
      if (REVKEY != simon_pkg::REVKEY_RECOMPUTE && REVKEY != simon_pkg::REVKEY_STORED) begin : g_bad_mode
         $error("simon_keysched: unknown REVKEY selection");
      end
   endgenerate

   // window of four consecutive round keys, w0 is the current one
   logic [WORD-1:0] w0, w1, w2, w3;
   logic [ZLEN-1:0] zr;

   function automatic logic [WORD-1:0] mixk(input logic [WORD-1:0] hi, input logic [WORD-1:0] lo);
      logic [WORD-1:0] t;
      t = {hi[2:0], hi[WORD-1:3]} ^ lo;
      return t ^ {t[0], t[WORD-1:1]};
   endfunction

   logic [WORD-1:0] nxt_fwd, nxt_bwd;

   always_comb begin
      nxt_fwd = w0 ^ mixk(w3, w1) ^ KCONST ^ {{(WORD-1){1'b0}}, zr[ZLEN-1]};
      nxt_bwd = w3 ^ mixk(w2, w0) ^ KCONST ^ {{(WORD-1){1'b0}}, zr[0]};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         w0 <= '0;
         w1 <= '0;
         w2 <= '0;
         w3 <= '0;
         zr <= '0;
      end else if (load_i) begin
         w0 <= key_i[WORD-1:0];
         w1 <= key_i[2*WORD-1:WORD];
         w2 <= key_i[3*WORD-1:2*WORD];
         w3 <= key_i[4*WORD-1:3*WORD];
         zr <= ZSEQ;
      end else if (fwd_i) begin
         w0 <= w1;
         w1 <= w2;
         w2 <= w3;
         w3 <= nxt_fwd;
         zr <= {zr[ZLEN-2:0], zr[ZLEN-1]};
      end else if (bwd_i) begin
         w3 <= w2;
         w2 <= w1;
         w1 <= w0;
         w0 <= nxt_bwd;
         zr <= {zr[0], zr[ZLEN-1:1]};
      end
   end

   generate
      if (REVKEY == simon_pkg::REVKEY_STORED) begin : g_stored
         localparam logic [CNT_W-1:0] LAST = CNT_W'(ROUNDS - 1);
         logic [WORD-1:0]  kmem [ROUNDS];
         logic [CNT_W-1:0] rd_idx;

         always_ff @(posedge clk) begin
            if (prep_i) kmem[idx_i] <= w0;
         end

         assign rd_idx = LAST - idx_i;
         assign rk_o   = (rev_i && idx_i != '0) ? kmem[rd_idx] : w0;
      end else begin : g_recompute
         logic unused_sel;
         assign unused_sel = ^{prep_i, rev_i, idx_i};
         assign rk_o = w0;
      end
   endgenerate

endmodule

// File: rtl/simon_ctrl.sv
module simon_ctrl #(
   parameter int  ROUNDS = 44,
   localparam int CNT_W  = $clog2(ROUNDS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             decrypt_i,
   output logic             load_o,
   output logic             prep_o,
   output logic             run_o,
   output logic             dec_o,
   output logic [CNT_W-1:0] idx_o,
   output logic             busy_o,
   output logic             done_o
);

   import simon_pkg::*;

   localparam logic [CNT_W-1:0] RUN_LAST  = CNT_W'(ROUNDS - 1);
   localparam logic [CNT_W-1:0] PREP_LAST = CNT_W'(ROUNDS - 2);

   generate
      if (ROUNDS < 5) begin : g_bad_rounds
         $error("simon_ctrl: ROUNDS must be at least 5");
      end
   endgenerate

   core_state_e      st;
   logic [CNT_W-1:0] cnt;
   logic             dec_q;
   logic             done_q;

   assign load_o = start_i && (st == ST_IDLE);
   assign prep_o = (st == ST_PREP);
   assign run_o  = (st == ST_RUN);
   assign dec_o  = dec_q;
   assign idx_o  = cnt;
   assign busy_o = (st != ST_IDLE);
   assign done_o = done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         cnt    <= '0;
         dec_q  <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (st)
            ST_IDLE: begin
               if (start_i) begin
                  dec_q <= decrypt_i;
                  cnt   <= '0;
                  st    <= decrypt_i ? ST_PREP : ST_RUN;
               end
            end
            ST_PREP: begin
               if (cnt == PREP_LAST) begin
                  cnt <= '0;
                  st  <= ST_RUN;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_RUN: begin
               if (cnt == RUN_LAST) begin
                  cnt    <= '0;
                  st     <= ST_IDLE;
                  done_q <= 1'b1;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/simon_core.sv
module simon_core #(
   parameter int              WORD   = 32,
   parameter int              ROUNDS = 44,
   parameter int              ZLEN   = 62,
   parameter logic [ZLEN-1:0] ZSEQ   = 62'b11011011101011000110010111100000010010001010011100110100001111,
   parameter int              REVKEY = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              decrypt_i,
   input  logic [2*WORD-1:0] block_i,
   input  logic [4*WORD-1:0] key_i,
   output logic              busy_o,
   output logic              done_o,
   output logic [2*WORD-1:0] block_o
);

   localparam int CNT_W = $clog2(ROUNDS);

   logic             load, prep, run, dec;
   logic [CNT_W-1:0] idx;
   logic [WORD-1:0]  rk;
   logic [WORD-1:0]  xq, yq, xn, yn;

   simon_ctrl #(.ROUNDS(ROUNDS)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start_i),
      .decrypt_i (decrypt_i),
      .load_o    (load),
      .prep_o    (prep),
      .run_o     (run),
      .dec_o     (dec),
      .idx_o     (idx),
      .busy_o    (busy_o),
      .done_o    (done_o)
   );

   simon_keysched #(
      .WORD   (WORD),
      .ROUNDS (ROUNDS),
      .ZLEN   (ZLEN),
      .ZSEQ   (ZSEQ),
      .REVKEY (REVKEY)
   ) u_ks (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (load),
      .key_i  (key_i),
      .fwd_i  (prep || (run && !dec)),
      .bwd_i  (run && dec),
      .prep_i (prep),
      .rev_i  (run && dec),
      .idx_i  (idx),
      .rk_o   (rk)
   );

   simon_round #(.WORD(WORD)) u_round (
      .x_i  (xq),
      .y_i  (yq),
      .rk_i (rk),
      .x_o  (xn),
      .y_o  (yn)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         xq <= '0;
         yq <= '0;
      end else if (load) begin
         // decryption enters with the halves exchanged
         xq <= decrypt_i ? block_i[WORD-1:0]      : block_i[2*WORD-1:WORD];
         yq <= decrypt_i ? block_i[2*WORD-1:WORD] : block_i[WORD-1:0];
      end else if (run) begin
         xq <= xn;
         yq <= yn;
      end
   end

   assign block_o = dec ? {yq, xq} : {xq, yq};

endmodule

// File: rtl/simon_core_chk.sv
module simon_core_chk #(
   parameter int  ROUNDS = 44,
   parameter int  BW     = 64,
   localparam int EW     = $clog2(2*ROUNDS + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start_i,
   input logic          decrypt_i,
   input logic          busy_o,
   input logic          done_o,
   input logic [BW-1:0] block_o
);

   logic          accept;
   logic [EW-1:0] cyc;
   logic [EW-1:0] due;

   assign accept = start_i && !busy_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cyc <= '0;
         due <= '0;
      end else if (accept) begin
         cyc <= '0;
         due <= decrypt_i ? EW'(2*ROUNDS - 1) : EW'(ROUNDS);
      end else if (busy_o) begin
         cyc <= cyc + 1'b1;
      end
   end

   // completion lands exactly on the cycle fixed at acceptance (R5, R6, R7)
   assert_done_on_time_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (cyc == due));

   assert_busy_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> (cyc < due));

   assert_accept_starts_R7: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> (busy_o && !done_o));

   assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_o && busy_o));

   assert_hold_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !start_i) |=> $stable(block_o));

endmodule

bind simon_core simon_core_chk #(.ROUNDS(ROUNDS), .BW(2*WORD)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start_i   (start_i),
   .decrypt_i (decrypt_i),
   .busy_o    (busy_o),
   .done_o    (done_o),
   .block_o   (block_o)
);

// File: tb/simon_core_tb.sv
`timescale 1ns/1ps
module simon_core_tb;

   localparam logic [61:0] ZREF = 62'b11011011101011000110010111100000010010001010011100110100001111;
   localparam logic [127:0] KAT_KEY = 128'h1b1a1918131211100b0a090803020100;
   localparam logic [63:0]  KAT_PT  = 64'h656b696c20646e75;
   localparam logic [63:0]  KAT_CT  = 64'h44c8fc20b9dfa07a;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start_i = 1'b0;
   logic         decrypt_i = 1'b0;
   logic [63:0]  block_i = '0;
   logic [127:0] key_i = '0;
   logic         busy_o, done_o;
   logic [63:0]  block_o;

   int checks = 0;
   int fails  = 0;
   logic [63:0] lcg = 64'h0123456789abcdef;

   always #2 clk = ~clk;

   simon_core u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start_i),
      .decrypt_i (decrypt_i),
      .block_i   (block_i),
      .key_i     (key_i),
      .busy_o    (busy_o),
      .done_o    (done_o),
      .block_o   (block_o)
   );

   function automatic logic [31:0] rl(input logic [31:0] v, input int s);
      return (v << s) | (v >> (32 - s));
   endfunction

   function automatic logic [31:0] rr(input logic [31:0] v, input int s);
      return (v >> s) | (v << (32 - s));
   endfunction

   // reference cipher written from R1, R2, R4
   function automatic logic [63:0] ref_enc(input logic [63:0] pt, input logic [127:0] key);
      logic [31:0] ks [44];
      logic [31:0] x, y, t;
      for (int i = 0; i < 4; i++) ks[i] = key[32*i +: 32];
      for (int i = 4; i < 44; i++) begin
         t = rr(ks[i-1], 3) ^ ks[i-3];
         ks[i] = ks[i-4] ^ t ^ rr(t, 1) ^ 32'hFFFFFFFC ^ {31'd0, ZREF[61 - ((i-4) % 62)]};
      end
      x = pt[63:32];
      y = pt[31:0];
      for (int i = 0; i < 44; i++) begin
         t = x;
         x = y ^ (rl(x, 1) & rl(x, 8)) ^ rl(x, 2) ^ ks[i];
         y = t;
      end
      return {x, y};
   endfunction

   function automatic logic [63:0] next_rand();
      lcg = lcg * 64'h5851f42d4c957f2d + 64'h14057b7ef767814f;
      return lcg;
   endfunction

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // issue one request and wait for completion; lat counts edges after acceptance
   task automatic run_op(input bit dec, input logic [63:0] blk, input logic [127:0] key,
                         output logic [63:0] res, output int lat);
      @(negedge clk);
      start_i = 1'b1;
      decrypt_i = dec;
      block_i = blk;
      key_i = key;
      @(posedge clk);
      #1;
      start_i = 1'b0;
      lat = 0;
      res = '0;
      while (lat < 300) begin
         @(posedge clk);
         #1;
         lat++;
         if (done_o) begin
            res = block_o;
            break;
         end
      end
   endtask

   task automatic t_reset();
      check(busy_o == 1'b0, "R9 busy after reset", {63'd0, busy_o}, 64'd0);
      check(done_o == 1'b0, "R9 done after reset", {63'd0, done_o}, 64'd0);
      check(block_o == 64'd0, "R9 block after reset", block_o, 64'd0);
   endtask

   task automatic t_kat();
      logic [63:0] r;
      int l;
      check(ref_enc(KAT_PT, KAT_KEY) == KAT_CT, "R3 reference model vector", ref_enc(KAT_PT, KAT_KEY), KAT_CT);
      run_op(1'b0, KAT_PT, KAT_KEY, r, l);
      check(r == KAT_CT, "R3 known-answer encrypt", r, KAT_CT);
      check(l == 44, "R5 encrypt latency", 64'(l), 64'd44);
      run_op(1'b1, KAT_CT, KAT_KEY, r, l);
      check(r == KAT_PT, "R6 known-answer decrypt", r, KAT_PT);
      check(l == 87, "R6 decrypt latency", 64'(l), 64'd87);
   endtask

   task automatic t_model(input logic [63:0] pt, input logic [127:0] key);
      logic [63:0] r, c, e;
      int l;
      e = ref_enc(pt, key);
      run_op(1'b0, pt, key, c, l);
      check(c == e, "R1 R2 R4 encrypt vs model", c, e);
      run_op(1'b1, c, key, r, l);
      check(r == pt, "R6 round trip", r, pt);
   endtask

   task automatic t_ignore();
      logic [63:0] e;
      int lat;
      e = ref_enc(KAT_CT, KAT_KEY);
      @(negedge clk);
      start_i = 1'b1;
      decrypt_i = 1'b0;
      block_i = KAT_CT;
      key_i = KAT_KEY;
      @(posedge clk);
      #1;
      start_i = 1'b0;
      lat = 0;
      while (lat < 300) begin
         @(posedge clk);
         #1;
         lat++;
         if (lat == 10 || lat == 43) begin
            start_i = 1'b1;
            decrypt_i = ~decrypt_i;
            block_i = ~block_i;
            key_i = ~key_i;
         end else begin
            start_i = 1'b0;
         end
         if (done_o) break;
      end
      start_i = 1'b0;
      check(lat == 44, "R7 ignored start keeps latency", 64'(lat), 64'd44);
      check(block_o == e, "R7 ignored start keeps result", block_o, e);
   endtask

   task automatic t_hold();
      logic [63:0] r;
      int l;
      run_op(1'b0, 64'hffffffff00000000, 128'd0, r, l);
      check(r == ref_enc(64'hffffffff00000000, 128'd0), "R2 zero key vs model", r, ref_enc(64'hffffffff00000000, 128'd0));
      @(posedge clk);
      #1;
      check(done_o == 1'b0, "R8 done is one cycle", {63'd0, done_o}, 64'd0);
      repeat (5) @(posedge clk);
      #1;
      check(block_o == r, "R8 result held", block_o, r);
      check(busy_o == 1'b0, "R8 idle after done", {63'd0, busy_o}, 64'd0);
   endtask

   initial begin : wdog
      #(4 * 200000);
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin : main
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1'b1;
      #1;
      t_reset();
      t_kat();
      t_model(64'd0, 128'd0);
      t_model({64{1'b1}}, {128{1'b1}});
      for (int n = 0; n < 6; n++) begin
         logic [63:0] p;
         logic [127:0] k;
         p = next_rand();
         k = {next_rand(), next_rand()};
         t_model(p, k);
      end
      t_ignore();
      t_hold();
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule